// File: doc/BRIEF.md
# PCM Receive Serial Port

This block takes in 8-bit PCM samples from a serial receive line and hands each finished sample to the sequencing logic of a voice codec. The serial side has its own data clock. It may run at any rate from 64 kHz to 4.096 MHz, and it has no fixed relation to any other clock on the chip. A rising edge on the word-enable input marks the sign bit of a new sample. Bits are taken on falling clock edges, most significant (sign) bit first. The finished sample is committed on the next rising edge.

Committed samples go into a two-slot hand-off store. Each slot raises its request into the sequencing-clock domain through a toggle synchronizer. A slot stays untouched until the consumer acknowledges it. Two samples may arrive in one frame for conferencing. When the second one lands while the first is still pending, it is flagged so the consumer can treat the two as a pair. A third sample that finds both slots busy is dropped.

Top module: `pcm_rx_port`

## Requirements
- R1: While reset is active and after it is released, `dec_req` is low until a complete sample has been received.
- R2: After `rx_en` rises, the next falling edge of `rx_clk` captures bit 7 (the sign bit) from `rx_dat`. The following seven falling edges capture bits 6 down to 0, so the delivered `dec_word` equals the serial bits taken most significant first.
- R3: A sample is committed on the first rising edge of `rx_clk` after its eighth capture. Its request then becomes visible on `dec_req` after passing a two-stage synchronizer clocked by `sq_clk`.
- R4: While `dec_req` is high, it stays high and `dec_word` and `dec_pair` stay stable until `dec_ack` is sampled high on a rising `sq_clk` edge. If no other sample is queued, `dec_req` is low in the following cycle.
- R5: If `rx_en` rises again before eight bits have been captured, the partial sample is discarded and capture restarts with a new sign bit. No request is raised for the partial sample.
- R6: A sample committed while the other slot is still unacknowledged is delivered with `dec_pair` = 1. A sample committed while no other slot is pending is delivered with `dec_pair` = 0.
- R7: A sample that completes while both slots are pending is dropped. No third request appears.
- R8: A `dec_ack` pulse while `dec_req` is low has no effect on later deliveries.
- R9: Samples are delivered on `dec_word` in the order in which they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| rx_clk | input | 1 | Serial receive data clock |
| rx_en | input | 1 | Word enable; its rising edge marks the sign bit |
| rx_dat | input | 1 | Serial receive data |
| sq_clk | input | 1 | Sequencing clock of the consumer |
| dec_ack | input | 1 | Consumer acknowledge, sampled on `sq_clk` |
| dec_req | output | 1 | A received sample is waiting to be decoded |
| dec_word | output | 8 | The waiting sample |
| dec_pair | output | 1 | The waiting sample is the second of a conferencing pair |

## Verification
The checker watches several behaviours on every cycle. On the consumer side, it confirms that an unacknowledged request holds and that the presented sample does not change while it waits. On the serial side, it confirms that an enable rise restarts the bit count and that a commit only happens after a full set of captures. The bench scenarios cover what needs whole sequences to show: the bit order of the delivered samples, the pair flag, dropping a sample when both slots are busy, discarding an interrupted sample, and a stray acknowledge leaving the queue intact.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;
  localparam int unsigned DEF_WORD_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned NUM_SLOTS       = 2;

  typedef logic slot_idx_t;
endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcmrx_shifter.sv
module pcmrx_shifter #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              rx_en,
  input  logic              rx_dat,
  output logic [WORD_W-1:0] word,
  output logic              commit,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // falling-edge capture state
  logic              en_q, en_n;
  logic [WORD_W-1:0] sh, sh_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              done_tgl, done_n;
  logic              sh_en;
  // rising-edge commit state
  logic              done_seen;

  always_comb begin
    en_n   = rx_en;
    cnt_n  = cnt;
    done_n = done_tgl;
    sh_en  = 1'b0;
    if (rx_en && !en_q) begin
      sh_en = 1'b1;
      cnt_n = ONE;
    end else if (cnt != '0 && cnt != FULL) begin
      sh_en = 1'b1;
      cnt_n = cnt + ONE;
    end
    sh_n = {sh[WORD_W-2:0], rx_dat};
    if (cnt_n == FULL && cnt != FULL) done_n = ~done_tgl;
  end

  always_ff @(negedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      en_q     <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      done_tgl <= 1'b0;
    end else begin
      en_q     <= en_n;
      cnt      <= cnt_n;
      done_tgl <= done_n;
      if (sh_en) sh <= sh_n;
    end
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) done_seen <= 1'b0;
    else           done_seen <= done_tgl;
  end

  assign commit  = done_tgl ^ done_seen;
  assign word    = sh;
  assign bit_cnt = cnt;
endmodule

// File: rtl/pcmrx_slots.sv
module pcmrx_slots
  import pcmrx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic                             rx_clk,
  input  logic                             rx_rst_n,
  input  logic                             commit,
  input  logic [WORD_W-1:0]                word,
  input  logic [NUM_SLOTS-1:0]             ack_s,
  output logic [NUM_SLOTS-1:0]             req_tgl,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0] ent_word,
  output logic [NUM_SLOTS-1:0]             ent_pair
);
  slot_idx_t            wp, wp_n;
  logic [NUM_SLOTS-1:0] pend, wr, req_n;
  logic                 accept;

  assign pend   = req_tgl ^ ack_s;
  assign accept = commit && !pend[wp];

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_wr
    assign wr[s] = accept && (wp == slot_idx_t'(s));
  end

  always_comb begin
    req_n = req_tgl ^ wr;
    wp_n  = wp ^ accept;
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      wp      <= 1'b0;
      req_tgl <= '0;
    end else begin
      wp      <= wp_n;
      req_tgl <= req_n;
    end
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      ent_word <= '0;
      ent_pair <= '0;
    end else begin
      for (int s = 0; s < int'(NUM_SLOTS); s++) begin
        if (wr[s]) begin
          ent_word[s] <= word;
          ent_pair[s] <= pend[s ^ 1];
        end
      end
    end
  end
endmodule

// File: rtl/pcmrx_issue.sv
module pcmrx_issue
  import pcmrx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic                             sq_clk,
  input  logic                             sq_rst_n,
  input  logic [NUM_SLOTS-1:0]             req_s,
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0] ent_word,
  input  logic [NUM_SLOTS-1:0]             ent_pair,
  input  logic                             dec_ack,
  output logic [NUM_SLOTS-1:0]             ack_tgl,
  output logic                             dec_req,
  output logic [WORD_W-1:0]                dec_word,
  output logic                             dec_pair
);
  slot_idx_t            rp, rp_n;
  logic [NUM_SLOTS-1:0] ack_n, take_vec;
  logic                 pend_r, take;

  assign pend_r = req_s[rp] ^ ack_tgl[rp];
  assign take   = dec_ack && pend_r;

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_take
    assign take_vec[s] = take && (rp == slot_idx_t'(s));
  end

  always_comb begin
    ack_n = ack_tgl ^ take_vec;
    rp_n  = rp ^ take;
  end

  always_ff @(posedge sq_clk or negedge sq_rst_n) begin
    if (!sq_rst_n) begin
      rp      <= 1'b0;
      ack_tgl <= '0;
    end else begin
      rp      <= rp_n;
      ack_tgl <= ack_n;
    end
  end

  assign dec_req  = pend_r;
  assign dec_word = ent_word[rp];
  assign dec_pair = ent_pair[rp];
endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
  import pcmrx_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1)
) (
  input  logic              rst_n,
  input  logic              rx_clk,
  input  logic              rx_en,
  input  logic              rx_dat,
  input  logic              sq_clk,
  input  logic              dec_ack,
  output logic              dec_req,
  output logic [WORD_W-1:0] dec_word,
  output logic              dec_pair
);
  logic                             rx_rst_n, sq_rst_n;
  logic [WORD_W-1:0]                rx_word;
  logic                             rx_commit;
  logic [CNT_W-1:0]                 rx_bit_cnt;
  logic [NUM_SLOTS-1:0]             req_tgl, req_s, ack_tgl, ack_s;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] ent_word;
  logic [NUM_SLOTS-1:0]             ent_pair;

  pcmrx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rx_rst (
    .clk(rx_clk), .rst_n(rst_n), .d(1'b1), .q(rx_rst_n));

  pcmrx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sq_rst (
    .clk(sq_clk), .rst_n(rst_n), .d(1'b1), .q(sq_rst_n));

  pcmrx_shifter #(.WORD_W(WORD_W)) u_shift (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_en(rx_en), .rx_dat(rx_dat),
    .word(rx_word), .commit(rx_commit), .bit_cnt(rx_bit_cnt));

  pcmrx_slots #(.WORD_W(WORD_W)) u_slots (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .commit(rx_commit), .word(rx_word),
    .ack_s(ack_s), .req_tgl(req_tgl), .ent_word(ent_word), .ent_pair(ent_pair));

  pcmrx_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(sq_clk), .rst_n(sq_rst_n), .d(req_tgl), .q(req_s));

  pcmrx_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(ack_tgl), .q(ack_s));

  pcmrx_issue #(.WORD_W(WORD_W)) u_issue (
    .sq_clk(sq_clk), .sq_rst_n(sq_rst_n), .req_s(req_s), .ent_word(ent_word),
    .ent_pair(ent_pair), .dec_ack(dec_ack), .ack_tgl(ack_tgl),
    .dec_req(dec_req), .dec_word(dec_word), .dec_pair(dec_pair));
endmodule

// File: rtl/pcmrx_chk.sv
module pcmrx_chk #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input logic              sq_clk,
  input logic              sq_rst_n,
  input logic              rx_clk,
  input logic              rx_rst_n,
  input logic              rx_en,
  input logic              dec_ack,
  input logic              dec_req,
  input logic [WORD_W-1:0] dec_word,
  input logic              dec_pair,
  input logic              commit,
  input logic [CNT_W-1:0]  bit_cnt
);
  always @(negedge sq_clk) begin
    if (sq_rst_n === 1'b0) begin
      // R1
      idle_in_reset_chk: assert (dec_req === 1'b0)
        else $error("request raised during reset");
    end
  end

  // R4
  hold_req_chk: assert property (@(posedge sq_clk) disable iff (!sq_rst_n)
    dec_req && !dec_ack |=> dec_req);

  // R4
  hold_word_chk: assert property (@(posedge sq_clk) disable iff (!sq_rst_n)
    dec_req && !dec_ack |=> $stable(dec_word) && $stable(dec_pair));

  // R5
  restart_count_chk: assert property (@(negedge rx_clk) disable iff (!rx_rst_n)
    $rose(rx_en) |=> bit_cnt == CNT_W'(1));

  // R3
  commit_full_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    commit |-> bit_cnt == CNT_W'(WORD_W));
endmodule

bind pcm_rx_port pcmrx_chk #(.WORD_W(WORD_W)) u_chk (
  .sq_clk(sq_clk), .sq_rst_n(sq_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
  .rx_en(rx_en), .dec_ack(dec_ack), .dec_req(dec_req), .dec_word(dec_word),
  .dec_pair(dec_pair), .commit(rx_commit), .bit_cnt(rx_bit_cnt));

// File: tb/pcm_rx_port_bench.sv
module pcm_rx_port_bench;
  localparam time SQ_PERIOD = 10ns;
  localparam time RX_HALF   = 31ns;

  logic       rst_n = 1'b0;
  logic       rx_clk = 1'b0;
  logic       sq_clk = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_dat = 1'b0;
  logic       dec_ack = 1'b0;
  logic       dec_req;
  logic [7:0] dec_word;
  logic       dec_pair;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #(SQ_PERIOD/2) sq_clk = ~sq_clk;
  always #(RX_HALF)     rx_clk = ~rx_clk;

  pcm_rx_port u_pcm_rx_port (
    .rst_n(rst_n), .rx_clk(rx_clk), .rx_en(rx_en), .rx_dat(rx_dat),
    .sq_clk(sq_clk), .dec_ack(dec_ack), .dec_req(dec_req),
    .dec_word(dec_word), .dec_pair(dec_pair));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w);
    @(posedge rx_clk); #5ns;
    rx_en  = 1'b1;
    rx_dat = w[7];
    for (int i = 6; i >= 0; i--) begin
      @(posedge rx_clk); #5ns;
      rx_dat = w[i];
    end
    @(posedge rx_clk); #5ns;
    rx_en = 1'b0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge sq_clk);
      if (dec_req) begin
        seen = 1'b1;
        return;
      end
    end
  endtask

  task automatic pulse_ack();
    dec_ack = 1'b1;
    @(negedge sq_clk);
    dec_ack = 1'b0;
  endtask

  task automatic take_word(input logic [7:0] w, input logic p, input string req);
    bit seen;
    wait_req(seen);
    check(seen, req, int'(seen), 1);
    check(dec_word == w, req, int'(dec_word), int'(w));
    check(dec_pair == p, req, int'(dec_pair), int'(p));
    pulse_ack();
  endtask

  task automatic expect_idle(input string req);
    repeat (60) @(negedge sq_clk);
    check(dec_req == 1'b0, req, int'(dec_req), 0);
  endtask

  task automatic gap();
    repeat (4) @(posedge rx_clk);
  endtask

  // R1
  task automatic t_reset();
    check(dec_req == 1'b0, "R1 reset", int'(dec_req), 0);
  endtask

  // R2 R3: bit order and commit of single samples
  task automatic t_single(input logic [7:0] w);
    send_word(w);
    take_word(w, 1'b0, "R2 R3 single");
    gap();
  endtask

  // R4: request and data held until acknowledge, dropped right after it
  task automatic t_hold();
    bit seen;
    send_word(8'hC3);
    wait_req(seen);
    check(seen, "R4 raised", int'(seen), 1);
    repeat (25) @(negedge sq_clk);
    check(dec_req == 1'b1, "R4 held", int'(dec_req), 1);
    check(dec_word == 8'hC3, "R4 word stable", int'(dec_word), 'hC3);
    pulse_ack();
    check(dec_req == 1'b0, "R4 released", int'(dec_req), 0);
    gap();
  endtask

  // R5: interrupted sample discarded
  task automatic t_restart();
    @(posedge rx_clk); #5ns;
    rx_en = 1'b1; rx_dat = 1'b1;
    repeat (3) begin
      @(posedge rx_clk); #5ns;
      rx_dat = ~rx_dat;
    end
    @(posedge rx_clk); #5ns;
    rx_en = 1'b0;
    send_word(8'h5A);
    take_word(8'h5A, 1'b0, "R5 restart");
    expect_idle("R5 no partial");
    gap();
  endtask

  // R6 R9: conferencing pair, arrival order kept
  task automatic t_pair();
    send_word(8'h11);
    send_word(8'h22);
    take_word(8'h11, 1'b0, "R6 R9 first");
    take_word(8'h22, 1'b1, "R6 R9 second");
    expect_idle("R6 drained");
    gap();
  endtask

  // R7: third sample dropped when both slots busy
  task automatic t_overrun();
    send_word(8'h33);
    send_word(8'h44);
    send_word(8'h55);
    take_word(8'h33, 1'b0, "R7 first");
    take_word(8'h44, 1'b1, "R7 second");
    expect_idle("R7 dropped");
    gap();
  endtask

  // R8: stray acknowledge ignored
  task automatic t_stray();
    @(negedge sq_clk);
    pulse_ack();
    repeat (3) @(negedge sq_clk);
    check(dec_req == 1'b0, "R8 idle", int'(dec_req), 0);
    send_word(8'h69);
    send_word(8'h96);
    take_word(8'h69, 1'b0, "R8 order first");
    take_word(8'h96, 1'b1, "R8 order second");
    expect_idle("R8 drained");
    gap();
  endtask

  initial begin
    repeat (6) @(posedge rx_clk);
    #3ns rst_n = 1'b1;
    repeat (4) @(posedge rx_clk);
    @(negedge sq_clk);
    t_reset();
    t_single(8'hA5);
    t_single(8'h00);
    t_single(8'hFF);
    t_single(8'h3C);
    t_hold();
    t_restart();
    t_pair();
    t_overrun();
    t_stray();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(SQ_PERIOD * 150000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule